// File: doc/BRIEF.md
# Mode-Dependent Memory Card Decoder

This block turns a 16-bit bus address into the select lines of one memory card. The card holds a single low ROM socket, a bank of high ROM sockets and a 1K RAM. An active-low card select goes low whenever any of the three memories is selected. Which addresses each memory answers depends on two mode inputs. One is a host-type strap (standard or alternate host). The other is a boot-phantom flag, which is high during the start-up phase when the card stands in at the bottom of memory.

Within the high ROM bank the block also drives one enable per socket. A static layout strap picks between two fillings: four 2K parts in the even sockets, or eight 1K parts. In the eight-part filling, address bit 10 separates the even sockets from the odd ones. Finally, the block gates the card's data-out buffer enable from the bus read strobes, and the RAM write enable from the memory-write strobe. Every output is a purely combinational function of the current inputs, so decode adds no clock latency.

Top module: `mem_card_decoder`

## Requirements
- R1: `card_sel_n` is 0 exactly when at least one of `lo_rom_sel`, `hi_rom_sel`, `ram_sel` is 1, and at most one of those three is 1 at any time.
- R2: Standard host (`alt_host`=0), normal run (`phantom`=0): `lo_rom_sel` covers C000–C7FF, `ram_sel` covers C800–CBFF, and `hi_rom_sel` covers E000–FFFF.
- R3: Standard host, phantom phase: only 0000–03FF is decoded. `lo_rom_sel` is set there when `lo_boot_open`=1. Otherwise `hi_rom_sel` is set there when `hi_boot_open`=1. The RAM never answers in this mode, and the low ROM wins when both straps are open.
- R4: Alternate host (`alt_host`=1), normal run: `hi_rom_sel` covers only E000–EFFF, `ram_sel` covers 0000–03FF, and `lo_rom_sel` is never set.
- R5: Alternate host, phantom phase: no select is ever set.
- R6: With `layout_1k`=0, bit i-1 of `sock_en` enables socket i, and only even sockets are used: socket 8 for offset 0000–07FF within the bank's 8K window, socket 6 for 0800–0FFF, socket 4 for 1000–17FF and socket 2 for 1800–1FFF. The offset is address bits 12..0.
- R7: With `layout_1k`=1, bits 12..10 of the address pick a 1K slot. Slot k uses socket 7-k when k is even (bit 10 low) and socket 9-k when k is odd (bit 10 high). For example, E000–E3FF is socket 7 and E400–E7FF is socket 8.
- R8: `sock_en` is all zero whenever `hi_rom_sel` is 0, and never has more than one bit set.
- R9: `dout_en` is 1 exactly when `card_sel_n` is 0 and both `dbin` and `memr` are 1.
- R10: `ram_we` is 1 exactly when `ram_sel` is 1 and `memwr` is 1.
- R11: For an address outside the active map, every select is off, `card_sel_n` is 1, and `dout_en` and `ram_we` stay 0 for any strobe combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | 16 | Bus address |
| alt_host | input | 1 | Host-type strap, 1 selects the alternate host map |
| phantom | input | 1 | Boot-phantom phase flag |
| lo_boot_open | input | 1 | Strap: low ROM may answer during phantom |
| hi_boot_open | input | 1 | Strap: high ROM bank may answer during phantom |
| layout_1k | input | 1 | Bank filling strap, 1 = eight 1K parts, 0 = four 2K parts |
| dbin | input | 1 | Bus data-in strobe |
| memr | input | 1 | Memory-read status |
| memwr | input | 1 | Memory-write strobe |
| card_sel_n | output | 1 | Card select, active low |
| lo_rom_sel | output | 1 | Low ROM select |
| hi_rom_sel | output | 1 | High ROM bank select |
| ram_sel | output | 1 | RAM select |
| sock_en | output | 8 | Per-socket enable in the high bank, bit i-1 = socket i |
| dout_en | output | 1 | Data-out buffer enable |
| ram_we | output | 1 | RAM write enable |

## Verification
The bench builds the block with its default eight-socket bank and 16-bit address. At that size, the full set of mode, strap, layout and strobe combinations can be crossed with an address sweep. The sweep steps through every 256-byte page and alternates the low byte between 00 and FF. As a result, both sides of every 1K map boundary are hit in all four host/phase modes and both layouts. It also exercises the priority case where both boot straps are open, and every strobe pattern on mapped and unmapped addresses.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
    localparam int ADDR_W   = 16;
    localparam int NUM_SOCK = 8;

    typedef struct packed {
        logic lo_rom;
        logic hi_rom;
        logic ram;
    } region_t;

    typedef enum logic [1:0] {
        MAP_STD_RUN  = 2'b00,
        MAP_STD_BOOT = 2'b01,
        MAP_ALT_RUN  = 2'b10,
        MAP_ALT_BOOT = 2'b11
    } map_mode_e;
endpackage

// File: rtl/mcd_map_decode.sv
module mcd_map_decode
    import mcd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              alt_host,
    input  logic              phantom,
    input  logic              lo_boot_open,
    input  logic              hi_boot_open,
    output region_t           region
);
    map_mode_e mode_d;
    logic      page0_d, lo_win_d, ram_win_d, hi_full_d, hi_half_d;
    region_t   region_d;

    always_comb begin
        mode_d    = map_mode_e'({alt_host, phantom});
        page0_d   = (addr[15:10] == 6'b000000);
        lo_win_d  = (addr[15:11] == 5'b11000);
        ram_win_d = (addr[15:10] == 6'b110010);
        hi_full_d = (addr[15:13] == 3'b111);
        hi_half_d = (addr[15:12] == 4'hE);
        region_d  = '0;
        unique case (mode_d)
            MAP_STD_RUN: begin
                region_d.lo_rom = lo_win_d;
                region_d.ram    = ram_win_d;
                region_d.hi_rom = hi_full_d;
            end
            MAP_STD_BOOT: begin
                region_d.lo_rom = page0_d && lo_boot_open;
                region_d.hi_rom = page0_d && hi_boot_open && !lo_boot_open;
            end
            MAP_ALT_RUN: begin
                region_d.hi_rom = hi_half_d;
                region_d.ram    = page0_d;
            end
            default: region_d = '0;
        endcase
    end

    assign region = region_d;

    always_comb begin
        assert_one_region_R1: assert ($onehot0({region.lo_rom, region.hi_rom, region.ram}));
        if (alt_host && phantom)
            assert_alt_boot_quiet_R5: assert (region == '0);
    end
endmodule

// File: rtl/mcd_bank_select.sv
module mcd_bank_select
    import mcd_pkg::*;
#(
    parameter int SOCKS = NUM_SOCK
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              bank_sel,
    input  logic              layout_1k,
    output logic [SOCKS-1:0]  sock_en
);
    localparam int PAIRS  = SOCKS / 2;
    localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    logic [PAIR_W-1:0] pair_d;
    logic [SOCKS-1:0]  en_d;

    assign pair_d = addr[11 +: PAIR_W];

    for (genvar s = 1; s <= SOCKS; s++) begin : g_sock
        localparam int PAIR_IDX = (SOCKS - s) / 2;
        localparam bit IS_EVEN  = (s % 2) == 0;
        always_comb begin
            en_d[s-1] = bank_sel && (pair_d == PAIR_W'(PAIR_IDX));
            if (layout_1k)
                en_d[s-1] = en_d[s-1] && (addr[10] == IS_EVEN);
            else
                en_d[s-1] = en_d[s-1] && IS_EVEN;
        end
    end

    assign sock_en = en_d;

    always_comb begin
        assert_sock_onehot_R8: assert ($onehot0(sock_en));
    end
endmodule

// File: rtl/mcd_bus_gate.sv
module mcd_bus_gate (
    input  logic card_act,
    input  logic ram_act,
    input  logic dbin,
    input  logic memr,
    input  logic memwr,
    output logic dout_en,
    output logic ram_we
);
    logic dout_d, we_d;

    always_comb begin
        dout_d = card_act && dbin && memr;
        we_d   = ram_act && memwr;
    end

    assign dout_en = dout_d;
    assign ram_we  = we_d;
endmodule

// File: rtl/mem_card_decoder.sv
module mem_card_decoder
    import mcd_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                alt_host,
    input  logic                phantom,
    input  logic                lo_boot_open,
    input  logic                hi_boot_open,
    input  logic                layout_1k,
    input  logic                dbin,
    input  logic                memr,
    input  logic                memwr,
    output logic                card_sel_n,
    output logic                lo_rom_sel,
    output logic                hi_rom_sel,
    output logic                ram_sel,
    output logic [NUM_SOCK-1:0] sock_en,
    output logic                dout_en,
    output logic                ram_we
);
    region_t region;
    logic    card_d;

    mcd_map_decode i_map (
        .addr         (addr),
        .alt_host     (alt_host),
        .phantom      (phantom),
        .lo_boot_open (lo_boot_open),
        .hi_boot_open (hi_boot_open),
        .region       (region)
    );

    assign card_d = region.lo_rom || region.hi_rom || region.ram;

    mcd_bank_select #(.SOCKS(NUM_SOCK)) i_bank (
        .addr      (addr),
        .bank_sel  (region.hi_rom),
        .layout_1k (layout_1k),
        .sock_en   (sock_en)
    );

    mcd_bus_gate i_gate (
        .card_act (card_d),
        .ram_act  (region.ram),
        .dbin     (dbin),
        .memr     (memr),
        .memwr    (memwr),
        .dout_en  (dout_en),
        .ram_we   (ram_we)
    );

    assign card_sel_n = !card_d;
    assign lo_rom_sel = region.lo_rom;
    assign hi_rom_sel = region.hi_rom;
    assign ram_sel    = region.ram;

    always_comb begin
        if (!hi_rom_sel)
            assert_sock_idle_R8: assert (sock_en == '0);
        if (dout_en)
            assert_dout_needs_card_R9: assert (!card_sel_n);
        if (ram_we)
            assert_we_only_ram_R10: assert (ram_sel && !lo_rom_sel && !hi_rom_sel);
    end
endmodule

// File: tb/test_mem_card_decoder.sv
module test_mem_card_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic [15:0] addr = '0;
    logic        alt_host = 0, phantom = 0, lo_boot_open = 0, hi_boot_open = 0;
    logic        layout_1k = 0, dbin = 0, memr = 0, memwr = 0;
    logic        card_sel_n, lo_rom_sel, hi_rom_sel, ram_sel, dout_en, ram_we;
    logic [7:0]  sock_en;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mem_card_decoder i_mem_card_decoder (
        .addr(addr), .alt_host(alt_host), .phantom(phantom),
        .lo_boot_open(lo_boot_open), .hi_boot_open(hi_boot_open),
        .layout_1k(layout_1k), .dbin(dbin), .memr(memr), .memwr(memwr),
        .card_sel_n(card_sel_n), .lo_rom_sel(lo_rom_sel), .hi_rom_sel(hi_rom_sel),
        .ram_sel(ram_sel), .sock_en(sock_en), .dout_en(dout_en), .ram_we(ram_we)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s addr=%h mode=%0d%0d straps=%0d%0d l1k=%0d actual=%h expected=%h",
                     tag, addr, alt_host, phantom, lo_boot_open, hi_boot_open, layout_1k, got, exp);
        end
    endtask

    function automatic int exp_sock(int a, bit hi, bit l1k);
        int off, idx, s;
        if (!hi) return 0;
        off = a % 8192;
        if (l1k) begin
            idx = off / 1024;
            s   = (idx % 2 == 0) ? 7 - idx : 9 - idx;
        end else begin
            s = 8 - 2 * (off / 2048);
        end
        return 1 << (s - 1);
    endfunction

    initial begin
        @(negedge clk);
        // Quiet state with strobes low at address 0 in standard run mode
        check("R11 idle card_sel_n", card_sel_n, 1);
        check("R9 idle dout_en", dout_en, 0);
        check("R10 idle ram_we", ram_we, 0);
        for (int m = 0; m < 4; m++)
            for (int st = 0; st < 4; st++)
                for (int l = 0; l < 2; l++)
                    for (int k = 0; k < 256; k++)
                        for (int sb = 0; sb < 8; sb++) begin
                            int a;
                            bit e_lo, e_hi, e_ram, any;
                            string tag;
                            a = k * 256 + ((k % 2 == 1) ? 255 : 0);
                            @(posedge clk);
                            addr = 16'(a);
                            alt_host = m[1]; phantom = m[0];
                            lo_boot_open = st[1]; hi_boot_open = st[0];
                            layout_1k = l[0];
                            dbin = sb[2]; memr = sb[1]; memwr = sb[0];
                            e_lo = 0; e_hi = 0; e_ram = 0;
                            case (m)
                                0: begin
                                    tag = "R2";
                                    e_lo  = a >= 'hC000 && a <= 'hC7FF;
                                    e_ram = a >= 'hC800 && a <= 'hCBFF;
                                    e_hi  = a >= 'hE000;
                                end
                                1: begin
                                    tag = "R3";
                                    e_lo = a < 'h400 && st[1];
                                    e_hi = a < 'h400 && st[0] && !st[1];
                                end
                                2: begin
                                    tag = "R4";
                                    e_hi  = a >= 'hE000 && a <= 'hEFFF;
                                    e_ram = a < 'h400;
                                end
                                default: tag = "R5";
                            endcase
                            any = e_lo || e_hi || e_ram;
                            @(negedge clk);
                            check({tag, " lo_rom_sel"}, lo_rom_sel, e_lo);
                            check({tag, " hi_rom_sel"}, hi_rom_sel, e_hi);
                            check({tag, " ram_sel"}, ram_sel, e_ram);
                            check("R1 card_sel_n", card_sel_n, !any);
                            if (!e_hi)      check("R8 sock_en idle", sock_en, 0);
                            else if (l == 1) check("R7 sock_en 1K", sock_en, exp_sock(a, 1, 1));
                            else             check("R6 sock_en 2K", sock_en, exp_sock(a, 1, 0));
                            check("R9 dout_en", dout_en, any && sb[2] && sb[1]);
                            check("R10 ram_we", ram_we, e_ram && sb[0]);
                            if (!any)
                                check("R11 unmapped quiet", {card_sel_n, dout_en, ram_we}, 3'b100);
                        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule